// File: doc/BRIEF.md
# Two-Bit Pseudo-Random Symbol Source

This block supplies one 2-bit pseudo-random symbol for each request. The generator behind it is an 8-bit Fibonacci shift register that starts from a fixed, nonzero seed. Because the stream depends only on that seed, the whole sequence can be rebuilt at any time by stepping the register forward from the seed.

A consumer raises `req_i` and waits for `done_o`. The block steps the register twice and collects one bit on each step. It then presents the pair on `sym_o` and holds `done_o` high until the consumer lowers `req_i`. Pulsing `reseed_i` returns the register to the seed, so two consumers that reseed at the same point see the same symbol stream.

Top module: `rnd2_source`

## Requirements
- R1: In the cycle after an edge where `rst_n` is low, `done_o` is 0 and `sym_o` is 2'b00, and the register holds the seed.
- R2: An edge with `reseed_i` high reloads the seed and clears `done_o` and `sym_o` to 0. The next request then returns the first symbol of the stream again.
- R3: One step computes the new bit 7 as bit 0 XOR bit 4 XOR bit 7, and moves bits 7..1 down into bits 6..0. The bit collected on a step is bit 0 as it was before that step.
- R4: `sym_o[1]` carries the bit collected on the first step of a request and `sym_o[0]` carries the bit from the second step.
- R5: After the edge that samples `req_i` high with `done_o` low, `done_o` stays low for one cycle. It goes high on the following edge, and `sym_o` becomes valid on that same edge.
- R6: While `req_i` stays high, `done_o` stays high and `sym_o` does not change. The edge that samples `req_i` low clears `done_o`.
- R7: Each request advances the register by exactly two steps. Holding `req_i` high after `done_o` rises starts no further steps.
- R8: `reseed_i` takes priority over `req_i`. It also aborts a request that is half done, and no symbol is delivered for that request.
- R9: The register never holds all zeros. If it ever did, the seed would be loaded back in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reseed_i | input | 1 | Synchronous reload of the fixed seed |
| req_i | input | 1 | Request level for one new symbol |
| sym_o | output | 2 | Last delivered symbol, first bit in the MSB |
| done_o | output | 1 | Symbol valid; held until the request drops |

## Verification
The assertions assume a consumer that keeps `req_i` high until `done_o` rises and then lowers it at some later point. They also assume `reseed_i` is a plain synchronous pulse that may arrive at any time. The stimulus follows that handshake: every random transaction holds the request for a random number of cycles after done and leaves a random idle gap. Reseeds come only between transactions, except in two directed cases. In one, a reseed lands on the same edge as a request start. In the other, a reseed aborts a request halfway, with the request withdrawn at the same time.

// File: rtl/rnd2_pkg.sv
// Package rnd2_pkg
// Shared types and the shift-register step for the 2-bit symbol source.
// Assumes a Fibonacci register whose new MSB is the XOR of the tapped bits.
package rnd2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SECOND = 2'd1,
        ST_HOLD   = 2'd2
    } rnd2_state_e;

    // One shift-register step: parity of the tapped bits enters at the MSB.
    function automatic logic [7:0] lfsr_step8(input logic [7:0] cur, input logic [7:0] taps);
        return {^(cur & taps), cur[7:1]};
    endfunction

endpackage

// File: rtl/rnd2_lfsr.sv
// Module rnd2_lfsr
// Holds the feedback shift register. It steps on request and reloads the
// seed on reset, on reseed, or if it ever finds itself in the all-zero state.
// Assumes SEED is neither all zeros nor all ones (both are fixed points).
module rnd2_lfsr #(
    parameter int          WIDTH = 8,
    parameter logic [7:0]  SEED  = 8'h5C,
    parameter logic [7:0]  TAPS  = 8'b1001_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic             bit_o,
    output logic [WIDTH-1:0] state_o
);
    import rnd2_pkg::*;

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] state_q;

    // Register update: seed load, zero guard, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            state_q <= SEED;
        end else if (state_q == ZERO) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= lfsr_step8(state_q, TAPS);
        end
    end

    assign bit_o   = state_q[0];
    assign state_o = state_q;

endmodule

// File: rtl/rnd2_ctrl.sv
// Module rnd2_ctrl
// Request/done sequencer. It pulls two serial bits from the shift register
// and packs them into a symbol, first bit in the MSB. It holds done until the
// request level drops. Assumes the register presents its output bit combinationally.
module rnd2_ctrl #(
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reseed_i,
    input  logic             req_i,
    input  logic             bit_i,
    output logic             step_o,
    output logic [SYM_W-1:0] sym_o,
    output logic             done_o
);
    import rnd2_pkg::*;

    rnd2_state_e state_q, state_d;
    logic        first_q;
    logic [SYM_W-1:0] sym_q;

    // Next state: start on a request, finish after the second bit, release on drop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_SECOND;
            ST_SECOND: state_d = ST_HOLD;
            ST_HOLD:   if (!req_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (reseed_i) state_d = ST_IDLE;
    end

    // A step is taken on both bit-collecting cycles unless a reseed wins.
    assign step_o = !reseed_i && ((state_q == ST_IDLE && req_i) || state_q == ST_SECOND);

    // State, first-bit capture and symbol register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            sym_q   <= '0;
        end else begin
            state_q <= state_d;
            if (reseed_i) begin
                sym_q <= '0;
            end else if (state_q == ST_IDLE && req_i) begin
                first_q <= bit_i;
            end else if (state_q == ST_SECOND) begin
                sym_q <= {first_q, bit_i};
            end
        end
    end

    assign sym_o  = sym_q;
    assign done_o = (state_q == ST_HOLD);

endmodule

// File: rtl/rnd2_source.sv
// Module rnd2_source (top)
// Handshaked source of 2-bit pseudo-random symbols built on an 8-bit
// Fibonacci register with taps at bits 0, 4 and 7. Assumes the consumer
// keeps the request high until done rises.
module rnd2_source #(
    parameter int         WIDTH = 8,
    parameter logic [7:0] SEED  = 8'h5C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reseed_i,
    input  logic       req_i,
    output logic [1:0] sym_o,
    output logic       done_o
);
    localparam logic [7:0] TAPS  = 8'b1001_0001;
    localparam int         SYM_W = 2;

    logic             step;
    logic             lfsr_bit;
    logic [WIDTH-1:0] lfsr_q;

    rnd2_lfsr #(.WIDTH(WIDTH), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (reseed_i),
        .step_i  (step),
        .bit_o   (lfsr_bit),
        .state_o (lfsr_q)
    );

    rnd2_ctrl #(.SYM_W(SYM_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reseed_i (reseed_i),
        .req_i    (req_i),
        .bit_i    (lfsr_bit),
        .step_o   (step),
        .sym_o    (sym_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/rnd2_source_chk.sv
// Module rnd2_source_chk
// Property checker bound to rnd2_source. It observes the ports and the
// register contents. Assumes a synchronous active-low reset.
module rnd2_source_chk #(
    parameter logic [7:0] SEED = 8'h5C
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reseed_i,
    input logic       req_i,
    input logic [1:0] sym_o,
    input logic       done_o,
    input logic [7:0] lfsr
);
    // R2 and R8: a reseed clears the handshake outputs.
    a_r2_reseed_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_i |=> (!done_o && sym_o == 2'b00));

    // R2: a reseed leaves the seed in the register.
    a_r2_reseed_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_i |=> (lfsr == SEED));

    // R3: the register either holds or moves by one feedback step.
    a_r3_step_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (!reseed_i && lfsr != 8'h00) |=> (lfsr == $past(lfsr)) ||
            (lfsr == {$past(lfsr[0]) ^ $past(lfsr[4]) ^ $past(lfsr[7]), $past(lfsr[7:1])}));

    // R5: done rises only while a request is pending.
    a_r5_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(req_i));

    // R6: done and the symbol hold while the request stays high.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && req_i && !reseed_i) |=> (done_o && $stable(sym_o)));

    // R6: dropping the request releases done.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !req_i) |=> !done_o);

    // R7: the register is frozen while done is held.
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !reseed_i) |=> $stable(lfsr));

    // R9: the register is never all zeros.
    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 8'h00);

endmodule

bind rnd2_source rnd2_source_chk #(.SEED(SEED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reseed_i (reseed_i),
    .req_i    (req_i),
    .sym_o    (sym_o),
    .done_o   (done_o),
    .lfsr     (lfsr_q)
);

// File: tb/sim_rnd2_source.sv
`timescale 1ns/1ps
// Bench for rnd2_source: directed corner cases plus seeded random transactions,
// checked against a reference stream rebuilt from the seed.
module sim_rnd2_source;

    localparam logic [7:0] SEED = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reseed_i = 1'b0;
    logic       req_i = 1'b0;
    logic [1:0] sym_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] model = SEED;

    always #2.5 clk = ~clk;

    rnd2_source #(.SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .reseed_i(reseed_i), .req_i(req_i),
        .sym_o(sym_o), .done_o(done_o)
    );

    // Reference step from R3: new MSB is b0^b4^b7, the rest move down.
    function automatic logic [7:0] ref_step(input logic [7:0] s);
        return {s[0] ^ s[4] ^ s[7], s[7:1]};
    endfunction

    // Next expected symbol per R3 and R4; advances the model by two steps.
    function automatic logic [1:0] ref_pull();
        logic b1, b0;
        b1 = model[0];
        model = ref_step(model);
        b0 = model[0];
        model = ref_step(model);
        return {b1, b0};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One full handshake with a hold of extra cycles after done rises.
    task automatic txn(input int hold);
        logic [1:0] exp;
        @(negedge clk) req_i = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0, "R5 done low after first edge", done_o, 0);
        @(negedge clk);
        exp = ref_pull();
        check(done_o == 1'b1, "R5 done after second edge", done_o, 1);
        check(sym_o == exp, "R3 R4 symbol value", sym_o, exp);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(done_o == 1'b1, "R6 done held", done_o, 1);
            check(sym_o == exp, "R6 R7 symbol stable", sym_o, exp);
        end
        req_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R6 done released", done_o, 0);
    endtask

    task automatic do_reseed();
        @(negedge clk) reseed_i = 1'b1;
        @(negedge clk) reseed_i = 1'b0;
        check(done_o == 1'b0, "R2 reseed clears done", done_o, 0);
        check(sym_o == 2'b00, "R2 reseed clears symbol", sym_o, 0);
        model = SEED;
    endtask

    initial begin
        logic [1:0] first_sym;
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(sym_o == 2'b00, "R1 reset symbol", sym_o, 0);

        // Stream from the seed right after reset.
        snap = model;
        txn(0);
        txn(2);
        txn(10);   // long hold: R7, no extra steps expected
        txn(0);

        // Replay after reseed: first symbol must repeat (R2).
        model = snap;
        first_sym = ref_pull();
        do_reseed();
        txn(1);
        check(sym_o == first_sym, "R2 replay of first symbol", sym_o, first_sym);

        // Reseed and request on the same edge (R8).
        @(negedge clk) begin req_i = 1'b1; reseed_i = 1'b1; end
        @(negedge clk);
        check(done_o == 1'b0, "R8 reseed beats request", done_o, 0);
        check(sym_o == 2'b00, "R8 symbol cleared", sym_o, 0);
        model = SEED;
        reseed_i = 1'b0;
        req_i = 1'b0;
        txn(0);

        // Reseed aborts a half-done request (R8).
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) begin reseed_i = 1'b1; req_i = 1'b0; end
        @(negedge clk);
        check(done_o == 1'b0, "R8 abort leaves done low", done_o, 0);
        check(sym_o == 2'b00, "R8 abort symbol cleared", sym_o, 0);
        reseed_i = 1'b0;
        model = SEED;
        @(negedge clk);
        check(done_o == 1'b0, "R8 no late delivery", done_o, 0);
        txn(0);

        // Seeded random traffic.
        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 10) == 0) do_reseed();
            txn($urandom % 6);
            repeat ($urandom % 4) @(negedge clk);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule